// File: doc/BRIEF.md
# Return-from-Interrupt Execution Unit

This unit carries out the return-from-interrupt operation of a simple 32-bit processor model. Each cycle it may accept one request: an instruction word, the current machine-state register (MSR), the saved program counter (SRR0), the saved machine state (SRR1) and a vector of pending exception requests. When the word is the return-from-interrupt encoding and the processor is in supervisor mode, the unit builds the new MSR. Only a fixed set of non-contiguous bits comes from SRR1, and every other bit keeps its current value. The unit then decides where fetch continues.

After the restore, the unit checks the pending requests against the new MSR. If one or more of them are now enabled, the one with the highest priority is taken at once. Fetch then goes to that exception's vector, and the word-aligned saved PC is reported as the value to store in SRR0. If none is enabled, fetch resumes at the word-aligned saved PC. If the operation is attempted in user mode, the unit raises a privilege-violation flag and changes neither the machine state nor the fetch address. Each operation that completes produces a one-cycle context-synchronisation pulse. Flushing the pipeline is left to the surrounding logic.

All results are registered, so they appear one cycle after the request. Bit positions below use LSB-first numbering: bit 0 is the least significant bit.

Top module: `rfi_exec_unit`

## Requirements
- R1: A request is recognised only when `req_valid` is high and `instr` equals 0x4C000064. This means bits 31:26 = 19, bits 25:11 = 0, bits 10:1 = 50 and bit 0 = 0. A recognised request raises `out_valid` one cycle later. Any other word, including a word that differs in a single bit, leaves `out_valid`, `exc_taken`, `priv_fault` and `sync_pulse` low in the next cycle.
- R2: On a recognised supervisor-mode request, `msr_out` takes bits 15:8, 6:4, 1 and 0 from `srr1_in` (mask 0x0000FF73). Every other bit comes from `msr_in`.
- R3: When no enabled exception is pending, `next_pc` becomes `{srr0_in[31:2], 2'b00}`.
- R4: Pending bits 0 to 2 count only when bit 15 (the external-interrupt enable) of the new MSR is 1. Pending bit 3 always counts.
- R5: Among the pending bits that count, the lowest index wins. `exc_taken` goes high, `exc_idx` gives that index, and `next_pc` becomes VEC_BASE + index × VEC_STRIDE (by default 0x500 + index × 0x100).
- R6: `srr0_save` equals `{srr0_in[31:2], 2'b00}` when an exception is taken, and 0 otherwise.
- R7: When bit 14 of `msr_in` (problem state) is 1, a recognised request sets `priv_fault`. In that case `msr_out` reports `msr_in` unchanged, `next_pc` holds its previous value, and `exc_taken` and `sync_pulse` stay low.
- R8: `sync_pulse` is high for exactly the cycle after each recognised supervisor-mode request, and low otherwise.
- R9: While `rst_n` is low at a clock edge, every output is cleared to zero.
- R10: Requests in consecutive cycles are each processed independently with a latency of one cycle. In cycles without a recognised request, `msr_out` and `next_pc` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| instr | input | 32 | Instruction word |
| msr_in | input | 32 | Current machine-state register |
| srr0_in | input | 32 | Saved program counter |
| srr1_in | input | 32 | Saved machine state |
| pend_in | input | N_EXC | Pending exception requests, bit 0 has the highest priority |
| out_valid | output | 1 | A recognised request was processed last cycle |
| msr_out | output | 32 | New machine-state value |
| next_pc | output | 32 | Next fetch address |
| exc_taken | output | 1 | An unmasked pending exception was taken |
| exc_idx | output | $clog2(N_EXC) | Index of the exception taken |
| srr0_save | output | 32 | Value to store in SRR0 when an exception is taken |
| priv_fault | output | 1 | The operation was attempted in user mode |
| sync_pulse | output | 1 | Context-synchronisation pulse |

## Verification
The bench builds the unit with its defaults: four pending lines, the top one non-maskable, a vector base of 0x500 and a stride of 0x100. With only four lines, every one of the sixteen pending patterns can be driven with the enable bit both set and clear, so the priority choice and the gating are covered exhaustively rather than by sampling. Random MSR and SRR1 pairs exercise the masked merge. Single-bit corruptions of the instruction word exercise every decoded field.

// File: rtl/rfi_pkg.sv
// Package: shared constants for the return-from-interrupt unit.
// Assumes LSB-first bit numbering throughout (bit 0 = least significant).
package rfi_pkg;
    localparam int          XLEN             = 32;
    localparam logic [5:0]  RFI_PRIMARY      = 6'd19;
    localparam logic [9:0]  RFI_EXTENDED     = 10'd50;
    localparam logic [31:0] MSR_RESTORE_MASK = 32'h0000_FF73;
    localparam int          EE_POS           = 15;
    localparam int          PR_POS           = 14;

    // Decoded fields of one instruction word
    typedef struct packed {
        logic [5:0]  primary;
        logic [14:0] reserved_mid;
        logic [9:0]  extended;
        logic        reserved_lsb;
    } instr_fields_t;
endpackage

// File: rtl/rfi_decode.sv
// Module: rfi_decode
// Recognises the return-from-interrupt encoding. All reserved fields must be zero.
// Purely combinational; assumes the word is stable while valid is high.
module rfi_decode
    import rfi_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output logic            is_rfi
);
    instr_fields_t f;

    // Split the word into its named fields
    always_comb f = instr_fields_t'(instr);

    // Match each field against the required encoding
    always_comb begin
        is_rfi = (f.primary == RFI_PRIMARY)
              && (f.reserved_mid == '0)
              && (f.extended == RFI_EXTENDED)
              && (f.reserved_lsb == 1'b0);
    end
endmodule

// File: rtl/rfi_msr_merge.sv
// Module: rfi_msr_merge
// Builds the restored machine state. Each bit selected by MASK comes from the
// saved state; every other bit is kept from the current MSR.
// Combinational; MASK is fixed at elaboration.
module rfi_msr_merge #(
    parameter int          W    = 32,
    parameter logic [31:0] MASK = 32'h0000_FF73
) (
    input  logic [W-1:0] cur_msr,
    input  logic [W-1:0] saved_msr,
    output logic [W-1:0] new_msr
);
    // One selector per bit, chosen at elaboration by the mask
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_restore
            assign new_msr[b] = saved_msr[b];
        end else begin : g_keep
            assign new_msr[b] = cur_msr[b];
        end
    end
endmodule

// File: rtl/rfi_exc_arbiter.sv
// Module: rfi_exc_arbiter
// Gates pending exceptions with the enable bit of the new MSR and picks the one
// with the lowest index. The top N_NMI lines ignore the enable bit.
// Combinational; assumes N_NMI <= N_EXC.
module rfi_exc_arbiter #(
    parameter int N_EXC = 4,
    parameter int N_NMI = 1,
    localparam int IDX_W = (N_EXC > 1) ? $clog2(N_EXC) : 1
) (
    input  logic [N_EXC-1:0] pend,
    input  logic             ext_enable,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N_EXC-1:0] eligible;

    // Per-line gating: maskable lines need the enable, the top lines do not
    for (genvar i = 0; i < N_EXC; i++) begin : g_gate
        if (i >= N_EXC - N_NMI) begin : g_nmi
            assign eligible[i] = pend[i];
        end else begin : g_mask
            assign eligible[i] = pend[i] & ext_enable;
        end
    end

    // Fixed priority: scan from the top down so the lowest index wins
    always_comb begin
        any = |eligible;
        idx = '0;
        for (int i = N_EXC - 1; i >= 0; i--) begin
            if (eligible[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rfi_exec_unit.sv
// Module: rfi_exec_unit (top)
// Executes one return-from-interrupt request per cycle. It restores the MSR,
// resolves the next fetch address (resume or exception vector) and flags user-mode
// attempts. All outputs are registered (latency one). Reset is synchronous, active low.
// Assumes inputs are stable around the rising edge while req_valid is high.
module rfi_exec_unit
    import rfi_pkg::*;
#(
    parameter int          N_EXC      = 4,
    parameter int          N_NMI      = 1,
    parameter logic [31:0] VEC_BASE   = 32'h0000_0500,
    parameter logic [31:0] VEC_STRIDE = 32'h0000_0100,
    localparam int IDX_W = (N_EXC > 1) ? $clog2(N_EXC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      instr,
    input  logic [31:0]      msr_in,
    input  logic [31:0]      srr0_in,
    input  logic [31:0]      srr1_in,
    input  logic [N_EXC-1:0] pend_in,
    output logic             out_valid,
    output logic [31:0]      msr_out,
    output logic [31:0]      next_pc,
    output logic             exc_taken,
    output logic [IDX_W-1:0] exc_idx,
    output logic [31:0]      srr0_save,
    output logic             priv_fault,
    output logic             sync_pulse
);
    logic             is_rfi;
    logic             fire;
    logic             user_mode;
    logic             go;
    logic [31:0]      merged_msr;
    logic             exc_any;
    logic [IDX_W-1:0] exc_sel;
    logic [31:0]      resume_pc;
    logic [31:0]      vector_pc;

    rfi_decode u_decode (
        .instr  (instr),
        .is_rfi (is_rfi)
    );

    rfi_msr_merge #(.W(XLEN), .MASK(MSR_RESTORE_MASK)) u_merge (
        .cur_msr   (msr_in),
        .saved_msr (srr1_in),
        .new_msr   (merged_msr)
    );

    rfi_exc_arbiter #(.N_EXC(N_EXC), .N_NMI(N_NMI)) u_arb (
        .pend       (pend_in),
        .ext_enable (merged_msr[EE_POS]),
        .any        (exc_any),
        .idx        (exc_sel)
    );

    // Qualify the request: recognised word, then the privilege level
    always_comb begin
        fire      = req_valid & is_rfi;
        user_mode = msr_in[PR_POS];
        go        = fire & ~user_mode;
    end

    // Candidate fetch addresses: aligned resume point and the exception vector
    always_comb begin
        resume_pc = {srr0_in[31:2], 2'b00};
        vector_pc = VEC_BASE + ({{(32-IDX_W){1'b0}}, exc_sel} * VEC_STRIDE);
    end

    // Result registers: flags every cycle, state only on a recognised request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            msr_out    <= '0;
            next_pc    <= '0;
            exc_taken  <= 1'b0;
            exc_idx    <= '0;
            srr0_save  <= '0;
            priv_fault <= 1'b0;
            sync_pulse <= 1'b0;
        end else begin
            out_valid  <= fire;
            priv_fault <= fire & user_mode;
            sync_pulse <= go;
            exc_taken  <= go & exc_any;
            exc_idx    <= (go & exc_any) ? exc_sel : '0;
            srr0_save  <= (go & exc_any) ? resume_pc : '0;
            if (fire) begin
                msr_out <= user_mode ? msr_in : merged_msr;
            end
            if (go) begin
                next_pc <= exc_any ? vector_pc : resume_pc;
            end
        end
    end
endmodule

// File: rtl/rfi_exec_chk.sv
// Module: rfi_exec_chk
// Assertion checker for rfi_exec_unit. It is attached by the bind statement at
// the end of this file and observes only the top-level ports.
module rfi_exec_chk
    import rfi_pkg::*;
#(
    parameter int N_EXC = 4,
    parameter int N_NMI = 1,
    localparam int IDX_W = (N_EXC > 1) ? $clog2(N_EXC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      instr,
    input logic [31:0]      msr_in,
    input logic [31:0]      srr0_in,
    input logic [31:0]      srr1_in,
    input logic [N_EXC-1:0] pend_in,
    input logic             out_valid,
    input logic [31:0]      msr_out,
    input logic [31:0]      next_pc,
    input logic             exc_taken,
    input logic [IDX_W-1:0] exc_idx,
    input logic [31:0]      srr0_save,
    input logic             priv_fault,
    input logic             sync_pulse
);
    // R2
    unmasked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !priv_fault) |-> (((msr_out ^ $past(msr_in)) & ~MSR_RESTORE_MASK) == 32'h0));

    // R2
    masked_bits_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !priv_fault) |-> (((msr_out ^ $past(srr1_in)) & MSR_RESTORE_MASK) == 32'h0));

    // R3
    resume_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !priv_fault && !exc_taken) |-> (next_pc == {$past(srr0_in[31:2]), 2'b00}));

    // R4
    masked_lines_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !msr_out[EE_POS]) |-> (int'(exc_idx) >= N_EXC - N_NMI));

    // R6
    saved_pc_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (srr0_save == {$past(srr0_in[31:2]), 2'b00}));

    // R7
    user_mode_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> (!exc_taken && !sync_pulse && msr_out == $past(msr_in) && $stable(next_pc)));

    // R8
    sync_only_on_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (out_valid && !priv_fault));

    // R1
    idle_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!exc_taken && !priv_fault && !sync_pulse));
endmodule

bind rfi_exec_unit rfi_exec_chk #(.N_EXC(N_EXC), .N_NMI(N_NMI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .instr      (instr),
    .msr_in     (msr_in),
    .srr0_in    (srr0_in),
    .srr1_in    (srr1_in),
    .pend_in    (pend_in),
    .out_valid  (out_valid),
    .msr_out    (msr_out),
    .next_pc    (next_pc),
    .exc_taken  (exc_taken),
    .exc_idx    (exc_idx),
    .srr0_save  (srr0_save),
    .priv_fault (priv_fault),
    .sync_pulse (sync_pulse)
);

// File: tb/rfi_exec_unit_test.sv
`timescale 1ns/1ps
// Bench for rfi_exec_unit. A behavioural reference model steps on each rising
// edge. The outputs are compared with it on every falling edge.
module rfi_exec_unit_test;
    localparam logic [31:0] RFI = 32'h4C00_0064;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0, msr_in = '0, srr0_in = '0, srr1_in = '0;
    logic [3:0]  pend_in = '0;
    logic        out_valid, exc_taken, priv_fault, sync_pulse;
    logic [31:0] msr_out, next_pc, srr0_save;
    logic [1:0]  exc_idx;

    // Expected state of the reference model
    logic        e_valid = 0, e_exc = 0, e_priv = 0, e_sync = 0;
    logic [31:0] e_msr = 0, e_pc = 0, e_save = 0;
    logic [1:0]  e_idx = 0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rfi_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .msr_in(msr_in), .srr0_in(srr0_in), .srr1_in(srr1_in), .pend_in(pend_in),
        .out_valid(out_valid), .msr_out(msr_out), .next_pc(next_pc),
        .exc_taken(exc_taken), .exc_idx(exc_idx), .srr0_save(srr0_save),
        .priv_fault(priv_fault), .sync_pulse(sync_pulse)
    );

    // True when LSB-index bit i is restored from SRR1 (R2)
    function automatic bit restored(int i);
        return (i >= 8 && i <= 15) || (i >= 4 && i <= 6) || i == 0 || i == 1;
    endfunction

    // Reference model: advances one step per rising edge
    always @(posedge clk) begin
        logic fire, user, found;
        logic [31:0] nm;
        int win;
        if (!rst_n) begin
            e_valid <= 0; e_exc <= 0; e_priv <= 0; e_sync <= 0;
            e_msr <= 0; e_pc <= 0; e_save <= 0; e_idx <= 0;
        end else begin
            fire = req_valid && instr[31:26] == 6'd19 && instr[25:11] == 0
                   && instr[10:1] == 10'd50 && !instr[0];
            user = msr_in[14];
            nm = msr_in;
            for (int i = 0; i < 32; i++) if (restored(i)) nm[i] = srr1_in[i];
            found = 0; win = 0;
            for (int k = 0; k < 4; k++)
                if (!found && pend_in[k] && (k == 3 || nm[15])) begin found = 1; win = k; end
            e_valid <= fire;
            e_priv  <= fire && user;
            e_sync  <= fire && !user;
            e_exc   <= fire && !user && found;
            e_idx   <= (fire && !user && found) ? 2'(win) : 2'd0;
            e_save  <= (fire && !user && found) ? (srr0_in & ~32'h3) : 32'h0;
            if (fire) e_msr <= user ? msr_in : nm;
            if (fire && !user) e_pc <= found ? 32'h500 + 32'(win) * 32'h100 : (srr0_in & ~32'h3);
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output on each falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(rst_n ? "R1" : "R9", "out_valid", 32'(out_valid), 32'(e_valid));
            chk(e_priv ? "R7" : "R2", "msr_out", msr_out, e_msr);
            chk(e_exc ? "R5" : "R3", "next_pc", next_pc, e_pc);
            chk("R4", "exc_taken", 32'(exc_taken), 32'(e_exc));
            chk("R5", "exc_idx", 32'(exc_idx), 32'(e_idx));
            chk("R6", "srr0_save", srr0_save, e_save);
            chk("R7", "priv_fault", 32'(priv_fault), 32'(e_priv));
            chk("R8", "sync_pulse", 32'(sync_pulse), 32'(e_sync));
        end
    end

    task automatic drive(logic v, logic [31:0] w, logic [31:0] m, logic [31:0] s0,
                         logic [31:0] s1, logic [3:0] p);
        @(negedge clk);
        req_valid <= v; instr <= w; msr_in <= m; srr0_in <= s0; srr1_in <= s1; pend_in <= p;
    endtask

    task automatic idle();
        drive(1'b0, $urandom, $urandom, $urandom, $urandom, 4'($urandom));
    endtask

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state is observed by the comparator during these cycles
        rst_n <= 1'b1;
        idle();
        // R2, R3: random MSR/SRR1 pairs, supervisor mode, nothing pending
        for (int n = 0; n < 200; n++)
            drive(1, RFI, $urandom & ~32'h4000, $urandom, $urandom, 4'h0);
        // R4, R5, R6: every pending pattern with the enable bit clear and set
        for (int p = 0; p < 16; p++)
            for (int ee = 0; ee < 2; ee++) begin
                drive(1, RFI, $urandom & ~32'h4000, $urandom,
                      ($urandom & ~32'h8000) | (32'(ee) << 15), 4'(p));
                idle();
            end
        // R7: user-mode attempts, with and without pending exceptions
        for (int n = 0; n < 20; n++)
            drive(1, RFI, $urandom | 32'h4000, $urandom, $urandom, 4'($urandom));
        // R1: single-bit corruptions of the encoding, and random words
        for (int b = 0; b < 32; b++)
            drive(1, RFI ^ (32'h1 << b), $urandom & ~32'h4000, $urandom, $urandom, 4'hF);
        for (int n = 0; n < 20; n++)
            drive(1, $urandom, $urandom, $urandom, $urandom, 4'($urandom));
        // R1: valid word with req_valid low
        drive(0, RFI, 32'h0, $urandom, $urandom, 4'hF);
        // R8, R10: back-to-back bursts separated by gaps
        for (int n = 0; n < 100; n++) begin
            drive(1, RFI, $urandom & ~32'h4000, $urandom, $urandom, 4'($urandom));
            if (n % 7 == 0) idle();
        end
        // R9: reset mid-run, then resume
        drive(1, RFI, 32'h0, 32'h1234_5677, 32'hFFFF_FFFF, 4'h1);
        rst_n <= 1'b0;
        idle(); idle();
        rst_n <= 1'b1;
        drive(1, RFI, 32'h0, 32'h0000_0ABF, 32'h0000_8000, 4'h4);
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule